// File: doc/BRIEF.md
# SPI Master with FIFO Status

This block is a serial peripheral master that moves 8-bit frames between two small on-chip FIFOs and a four-wire serial link. Software or a neighbouring block queues bytes through a transmit stream port and collects received bytes through a receive stream port. An enable input gates all activity, and a 2-bit transfer mode selects full-duplex, transmit-only or receive-only operation. Status outputs show a busy flag, a per-FIFO 2-bit occupancy code and a sticky transmit overflow flag. Together they let the owner confirm that the link has drained before it shuts the block down. The safe order is: transmit level 00, then busy low, then enable low, then read until the receive level is 00.

In the two transmit modes the serial clock runs only while transmit data is queued, and frames follow each other with no gap while the queue is non-empty. In receive-only mode the block clocks frames back to back for as long as it is enabled and the receive FIFO has room. Clearing the enable input during a frame lets that frame finish and be stored, and no further frame starts. Frames already in the receive FIFO stay readable after the block is disabled.

Both data ports are valid/ready streams. On the transmit side, `tx_ready` is high whenever the FIFO has a free entry, and a byte is taken on any cycle where `tx_valid` and `tx_ready` are both high. A `tx_valid` pulse while `tx_ready` is low is not stalled: the byte is discarded and the overflow flag is set. On the receive side, `rx_valid` is high while the FIFO holds data, and `rx_data` shows the oldest byte. That byte is removed on a cycle where `rx_valid` and `rx_ready` are both high. Receive back-pressure is honoured by never starting a frame that has nowhere to land.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, busy=0, ss_n=1, sck=0, mosi=0, tx_ready=1, tx_overflow=0, rx_valid=0, and both level codes are 00.
- R2: tx_ready is high while the transmit FIFO holds fewer than 4 bytes. A tx_valid cycle with tx_ready low discards the byte and sets tx_overflow, which stays set until reset.
- R3: Each FIFO's level code is 00 when empty, 01 with 1 entry, 10 with 2 entries, and 11 with 3 or 4 entries (4-entry FIFOs).
- R4: mode 00 is full-duplex, 01 transmit-only, 10 receive-only, and 11 is reserved and never starts a frame. Frames are 8 bits, MSB first. mosi changes on the falling sck edge and miso is sampled on the rising sck edge (sck idles low). Each sck half period is DIV_HALF system clocks, so one isolated frame keeps busy high for 16*DIV_HALF cycles.
- R5: ss_n is low exactly while busy is high, and sck is low whenever busy is low. The first rising sck edge of a burst comes DIV_HALF clocks after ss_n falls.
- R6: In full-duplex mode each queued byte is sent on mosi. The byte sampled from miso enters the receive FIFO as its last bit is sampled, and rx_valid is high exactly while the receive level is not 00.
- R7: In the transmit modes, queued bytes go out back to back with ss_n held low between them. busy clears at the end of the frame that empties the transmit FIFO.
- R8: In transmit-only mode received bits are discarded and the receive FIFO does not change.
- R9: In receive-only mode mosi is held low, the transmit FIFO is neither read nor changed, and frames repeat back to back while enable stays high.
- R10: Clearing enable while a frame is in progress lets that frame complete and be stored. No further frame is clocked.
- R11: A frame in full-duplex or receive-only mode starts only when the receive FIFO has a free entry. Otherwise the block idles and resumes once a byte is read.
- R12: Received bytes left in the receive FIFO when enable is cleared stay readable afterwards, oldest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows frames to start |
| mode | input | 2 | Transfer mode: 00 duplex, 01 transmit-only, 10 receive-only, 11 reserved |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit FIFO has a free entry |
| tx_overflow | output | 1 | Sticky: a byte was offered while tx_ready was low |
| tx_level | output | 2 | Transmit FIFO occupancy code |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Consumer takes rx_data |
| rx_level | output | 2 | Receive FIFO occupancy code |
| busy | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong bit counter or divider count shows up at once as a wrong busy length or a wrong byte on mosi or rx_data. It is therefore caught at the end of the first frame after the fault, within 16*DIV_HALF cycles. A corrupted FIFO pointer or count shows on the level codes and on the order of bytes read back, and the bench compares these after every push, pop and burst. A wrong stop decision, such as an extra frame after enable falls, a frame started into a full receive FIFO, or a gap in a transmit burst, is seen as a frame count or busy-cycle total that differs from what the queued data and the mode require.

// File: rtl/spi_fm_pkg.sv
`timescale 1ns/1ps
package spi_fm_pkg;
  typedef enum logic [1:0] {
    XFER_DUPLEX   = 2'b00,
    XFER_TX_ONLY  = 2'b01,
    XFER_RX_ONLY  = 2'b10,
    XFER_RESERVED = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'b00,
    ENG_LOW  = 2'b01,
    ENG_HIGH = 2'b10
  } eng_state_e;
endpackage

// File: rtl/spi_fm_fifo.sv
`timescale 1ns/1ps
module spi_fm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic [1:0]   level
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam int TQ   = (3 * DEPTH) / 4;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign head    = mem[rp];

  // occupancy code: empty, under half, under three-quarters, at or above
  always_comb begin
    if (cnt >= CW'(TQ))        level = 2'b11;
    else if (cnt >= CW'(HALF)) level = 2'b10;
    else if (cnt != '0)        level = 2'b01;
    else                       level = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      unique case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_fm_engine.sv
`timescale 1ns/1ps
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIV_HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  xfer_mode_e   mode,
  input  logic         tx_avail,
  input  logic [W-1:0] tx_head,
  output logic         tx_pop,
  input  logic         rx_space,
  output logic         rx_push,
  output logic [W-1:0] rx_word,
  output logic         busy,
  output xfer_mode_e   cur_mode,
  output logic         sck,
  output logic         ss_n,
  output logic         mosi,
  input  logic         miso
);
  localparam int CNTW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BW   = (W > 1) ? $clog2(W) : 1;

  eng_state_e      state;
  logic [CNTW-1:0] cnt;
  logic [BW-1:0]   bitc;
  logic [W-1:0]    txsh;
  logic [W-2:0]    rxsh;
  logic            sck_q, ssn_q;
  logic            can_start, half_done, last_bit, frame_end, load;

  assign half_done = (cnt == CNTW'(DIV_HALF - 1));
  assign last_bit  = (bitc == BW'(W - 1));
  assign frame_end = (state == ENG_HIGH) && half_done && last_bit;

  // a frame may start only if its data source and sink are both available
  always_comb begin
    case (mode)
      XFER_DUPLEX:  can_start = tx_avail && rx_space;
      XFER_TX_ONLY: can_start = tx_avail;
      XFER_RX_ONLY: can_start = rx_space;
      default:      can_start = 1'b0;
    endcase
    can_start = can_start && enable;
  end

  assign load    = can_start && ((state == ENG_IDLE) || frame_end);
  assign tx_pop  = load && (mode != XFER_RX_ONLY);
  assign rx_word = {rxsh, miso};
  assign rx_push = (state == ENG_LOW) && half_done && last_bit &&
                   (cur_mode != XFER_TX_ONLY);
  assign busy    = (state != ENG_IDLE);
  assign sck     = sck_q;
  assign ss_n    = ssn_q;
  assign mosi    = busy && (cur_mode != XFER_RX_ONLY) && txsh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      cnt      <= '0;
      bitc     <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      sck_q    <= 1'b0;
      ssn_q    <= 1'b1;
      cur_mode <= XFER_DUPLEX;
    end else if (load) begin
      state    <= ENG_LOW;
      cnt      <= '0;
      bitc     <= '0;
      sck_q    <= 1'b0;
      ssn_q    <= 1'b0;
      cur_mode <= mode;
      txsh     <= (mode == XFER_RX_ONLY) ? '0 : tx_head;
    end else begin
      case (state)
        ENG_LOW: begin
          if (half_done) begin
            cnt   <= '0;
            sck_q <= 1'b1;
            rxsh  <= rx_word[W-2:0];
            state <= ENG_HIGH;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        ENG_HIGH: begin
          if (half_done) begin
            cnt   <= '0;
            sck_q <= 1'b0;
            if (last_bit) begin
              state <= ENG_IDLE;
              ssn_q <= 1'b1;
            end else begin
              bitc  <= bitc + BW'(1);
              txsh  <= {txsh[W-2:0], 1'b0};
              state <= ENG_LOW;
            end
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        ENG_IDLE: ;
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master
  import spi_fm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_overflow,
  output logic [1:0]        tx_level,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic [1:0]        rx_level,
  output logic              busy,
  output logic              sck,
  output logic              ss_n,
  output logic              mosi,
  input  logic              miso
);
  logic [DATA_W-1:0] tx_head, rx_word;
  logic              tx_full, tx_empty, tx_pop;
  logic              rx_full, rx_empty, rx_push;
  logic              ovf_q;
  xfer_mode_e        eng_mode;

  spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_valid), .push_data(tx_data), .pop(tx_pop),
    .head(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_word), .pop(rx_ready),
    .head(rx_data), .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  spi_fm_engine #(.W(DATA_W), .DIV_HALF(DIV_HALF)) u_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(xfer_mode_e'(mode)),
    .tx_avail(!tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
    .rx_space(!rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .busy(busy), .cur_mode(eng_mode),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso)
  );

  assign tx_ready    = !tx_full;
  assign rx_valid    = !rx_empty;
  assign tx_overflow = ovf_q;

  // sticky: an offered byte with no room is lost, and that is remembered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf_q <= 1'b0;
    else if (tx_valid && tx_full) ovf_q <= 1'b1;
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
`timescale 1ns/1ps
module spi_fifo_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] mode,
  input logic [1:0] act_mode,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_overflow,
  input logic [1:0] tx_level,
  input logic       rx_valid,
  input logic [1:0] rx_level,
  input logic       busy,
  input logic       sck,
  input logic       mosi,
  input logic       ss_n
);
  assert_ss_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n == !busy);

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);

  assert_drop_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_overflow);

  assert_ready_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level != 2'b11) |-> tx_ready);

  assert_rx_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid == (rx_level != 2'b00));

  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(enable) && $past(mode) != 2'b11));

  assert_rxonly_mosi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && act_mode == 2'b10) |-> !mosi);

  assert_txonly_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && act_mode == 2'b01 && $past(act_mode) == 2'b01)
      |-> (rx_level <= $past(rx_level)));
endmodule

bind spi_fifo_master spi_fifo_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .act_mode(eng_mode),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_overflow(tx_overflow),
  .tx_level(tx_level), .rx_valid(rx_valid), .rx_level(rx_level),
  .busy(busy), .sck(sck), .mosi(mosi), .ss_n(ss_n)
);

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  localparam int DH    = 2;
  localparam int FRAME = 16 * DH;
  localparam int WDOG  = 20000;
  // each entry: {byte queued for mosi, byte the slave returns on miso}
  localparam logic [15:0] VEC [0:4] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                        16'h81_7E, 16'h5A_C3};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       enable = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, tx_overflow, rx_valid, busy, sck, ss_n, mosi, miso;
  logic [1:0] tx_level, rx_level;
  logic [7:0] rx_data;

  spi_fifo_master #(.DATA_W(8), .FIFO_DEPTH(4), .DIV_HALF(DH)) i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_overflow(tx_overflow), .tx_level(tx_level),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_level(rx_level), .busy(busy), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int busy_cyc = 0, ss_gap = 0, mosi_hi = 0;

  // slave model: presents bytes on miso, captures mosi bytes
  logic [7:0] slv_mem [32];
  logic [7:0] cap_mem [32];
  logic [7:0] cap_sh = 8'h00;
  int fr_cnt = 0, rcv_bit = 0, drv_frame = 0, drv_bit = 0;

  assign miso = slv_mem[drv_frame % 32][3'(7 - drv_bit)];

  always @(posedge sck) begin
    cap_sh = {cap_sh[6:0], mosi};
    rcv_bit++;
    if (rcv_bit == 8) begin
      cap_mem[fr_cnt % 32] = cap_sh;
      fr_cnt++;
      rcv_bit = 0;
    end
  end

  always @(negedge sck) begin
    if (drv_bit == 7) begin drv_bit = 0; drv_frame++; end
    else drv_bit++;
  end

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (busy === 1'b1) busy_cyc++;
    if (busy === 1'b1 && ss_n === 1'b1) ss_gap++;
    if (busy === 1'b1 && mosi === 1'b1) mosi_hi++;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    b = rx_data; rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_busy(input logic lvl, input int maxc, input string req);
    int n;
    n = 0;
    while (busy !== lvl && n < maxc) begin @(negedge clk); n++; end
    if (busy !== lvl) chk(req, "busy wait timeout", 32'(busy), 32'(lvl));
  endtask

  task automatic wait_frames(input int target, input int maxc, input string req);
    int n;
    n = 0;
    while (fr_cnt < target && n < maxc) begin @(negedge clk); n++; end
    if (fr_cnt < target) chk(req, "frame wait timeout", 32'(fr_cnt), 32'(target));
  endtask

  initial begin : watchdog
    wait (cyc >= WDOG);
    n_chk++; n_err++;
    $display("FAIL all requirements: watchdog expired actual=%0d expected<%0d", cyc, WDOG);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    int base, b0, lead;
    for (int i = 0; i < 32; i++) begin slv_mem[i] = 8'h00; cap_mem[i] = 8'h00; end
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "ss_n", 32'(ss_n), 1);
    chk("R1", "sck", 32'(sck), 0);
    chk("R1", "mosi", 32'(mosi), 0);
    chk("R1", "tx_ready", 32'(tx_ready), 1);
    chk("R1", "tx_overflow", 32'(tx_overflow), 0);
    chk("R1", "rx_valid", 32'(rx_valid), 0);
    chk("R1", "levels", 32'({tx_level, rx_level}), 0);

    // vector walk: full duplex, one frame per entry (R4 R6)
    mode = 2'b00; enable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      base = fr_cnt;
      slv_mem[base % 32] = VEC[i][7:0];
      push_tx(VEC[i][15:8]);
      wait_busy(1'b1, 10, "R6");
      wait_busy(1'b0, FRAME + 8, "R6");
      chk("R4", "mosi byte MSB first", 32'(cap_mem[base % 32]), 32'(VEC[i][15:8]));
      chk("R6", "rx_valid after frame", 32'(rx_valid), 1);
      chk("R6", "rx byte", 32'(rx_data), 32'(VEC[i][7:0]));
      pop_rx(b);
      chk("R5", "ss_n high when idle", 32'(ss_n), 1);
    end
    enable = 1'b0;

    // R5 lead time and R4 frame length, transmit-only
    base = fr_cnt; b0 = busy_cyc;
    push_tx(8'hC9);
    mode = 2'b01; enable = 1'b1;
    lead = 0;
    for (int c = 0; c < 40 && sck !== 1'b1; c++) begin
      @(negedge clk);
      if (ss_n === 1'b0 && sck === 1'b0) lead++;
    end
    chk("R5", "ss_n to first sck rise", 32'(lead), 32'(DH));
    wait_busy(1'b0, FRAME + 8, "R4");
    chk("R4", "busy cycles per frame", 32'(busy_cyc - b0), 32'(FRAME));
    chk("R4", "tx-only byte", 32'(cap_mem[base % 32]), 32'h0C9);
    enable = 1'b0;

    // R3 level codes and R2 overflow, with the link disabled
    push_tx(8'h11); chk("R3", "tx_level 1 entry", 32'(tx_level), 32'h1);
    push_tx(8'h22); chk("R3", "tx_level 2 entries", 32'(tx_level), 32'h2);
    push_tx(8'h33); chk("R3", "tx_level 3 entries", 32'(tx_level), 32'h3);
    chk("R2", "tx_ready with 3 entries", 32'(tx_ready), 1);
    push_tx(8'h44); chk("R3", "tx_level 4 entries", 32'(tx_level), 32'h3);
    chk("R2", "tx_ready when full", 32'(tx_ready), 0);
    chk("R2", "no overflow yet", 32'(tx_overflow), 0);
    push_tx(8'h55);
    chk("R2", "overflow on dropped write", 32'(tx_overflow), 1);
    tick(10);
    chk("R2", "overflow sticky", 32'(tx_overflow), 1);

    // R7 back-to-back burst, R8 transmit-only leaves receive FIFO alone
    base = fr_cnt; b0 = busy_cyc; ss_gap = 0;
    mode = 2'b01; enable = 1'b1;
    wait_busy(1'b1, 10, "R7");
    wait_busy(1'b0, 4 * FRAME + 8, "R7");
    chk("R7", "frames in burst", 32'(fr_cnt - base), 4);
    chk("R7", "burst busy cycles", 32'(busy_cyc - b0), 32'(4 * FRAME));
    chk("R7", "ss_n stayed low in burst", 32'(ss_gap), 0);
    for (int k = 0; k < 4; k++)
      chk("R7", "burst byte order", 32'(cap_mem[(base + k) % 32]), 32'(8'h11 * (k + 1)));
    chk("R7", "tx drained", 32'(tx_level), 0);
    chk("R8", "rx_level unchanged", 32'(rx_level), 0);
    enable = 1'b0;

    // R9 R10 R12 receive-only stream stopped mid-frame
    push_tx(8'h99);
    base = fr_cnt; mosi_hi = 0;
    for (int k = 0; k < 6; k++) slv_mem[(base + k) % 32] = 8'hC1 + 8'(k * 17);
    mode = 2'b10; enable = 1'b1;
    wait_frames(base + 2, 3 * FRAME, "R9");
    tick(4 * DH);
    enable = 1'b0;
    wait_busy(1'b0, FRAME + 8, "R10");
    chk("R10", "frames after enable cleared", 32'(fr_cnt - base), 3);
    chk("R3", "rx_level 3 entries", 32'(rx_level), 32'h3);
    chk("R9", "tx FIFO untouched", 32'(tx_level), 32'h1);
    chk("R9", "mosi held low", 32'(mosi_hi), 0);
    for (int k = 0; k < 3; k++) begin
      pop_rx(b);
      chk("R12", "retained byte", 32'(b), 32'(8'hC1 + 8'(k * 17)));
    end
    chk("R12", "rx drained", 32'(rx_level), 0);

    // R11 receive FIFO full stalls the stream, a read resumes it
    base = fr_cnt;
    for (int k = 0; k < 6; k++) slv_mem[(base + k) % 32] = 8'h30 + 8'(k);
    enable = 1'b1;
    tick(6 * FRAME + 20);
    chk("R11", "stalled when full", 32'(busy), 0);
    chk("R11", "frames before stall", 32'(fr_cnt - base), 4);
    chk("R3", "rx_level full", 32'(rx_level), 32'h3);
    pop_rx(b);
    chk("R11", "first byte", 32'(b), 32'h30);
    wait_busy(1'b1, 10, "R11");
    enable = 1'b0;
    wait_busy(1'b0, FRAME + 8, "R11");
    chk("R11", "one frame after read", 32'(fr_cnt - base), 5);
    for (int k = 1; k < 5; k++) begin
      pop_rx(b);
      chk("R11", "byte order after stall", 32'(b), 32'(8'h30 + 8'(k)));
    end

    // R4 reserved mode never starts
    b0 = busy_cyc;
    mode = 2'b11; enable = 1'b1;
    tick(40);
    chk("R4", "reserved mode idle", 32'(busy_cyc - b0), 0);
    chk("R4", "reserved keeps tx", 32'(tx_level), 32'h1);
    base = fr_cnt; slv_mem[base % 32] = 8'h5A;
    mode = 2'b00;
    wait_busy(1'b1, 10, "R6");
    enable = 1'b0;
    wait_busy(1'b0, FRAME + 8, "R6");
    chk("R6", "duplex byte out", 32'(cap_mem[base % 32]), 32'h99);
    chk("R6", "duplex byte in", 32'(rx_data), 32'h5A);
    pop_rx(b);

    // R1 reset clears the sticky flag
    chk("R2", "overflow held before reset", 32'(tx_overflow), 1);
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
    chk("R1", "overflow cleared by reset", 32'(tx_overflow), 0);
    chk("R1", "tx_ready after reset", 32'(tx_ready), 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule